// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block sits beside the execution control of a pipelined processor and turns a set of exception and interrupt request lines into a redirect of the program counter. Instruction faults, address faults, timer ticks and message-buffer interrupts all arrive on one request vector and share the same path. A request line only needs to pulse for one cycle. The block latches it as pending and keeps it until it is accepted.

While exception recognition is enabled, the block accepts a request in the same cycle it is seen. In that cycle it picks the winner by fixed priority, saves the interrupted state into shadow registers and computes the handler address. At the next clock edge it loads the program counter, flushes the younger instructions and sets the status word to supervisor mode with recognition switched off. A return-from-exception strobe reverses this. It copies the shadowed status back and sends the program counter to the saved instruction address.

The status word is held inside the block. The pipeline may overwrite it through a plain write strobe, and this is how a handler turns recognition back on.

Top module: `exc_entry_ctrl`

## Requirements
- R1: When several requests are pending together, the lowest request index wins. On the edge that accepts it, `cause_o` is loaded with that index.
- R2: On acceptance, `epc_o` captures `pc_i` and `esw_o` captures the status word as it stood before entry.
- R3: `bad_addr_o` captures `fault_addr_i` only when the winning index is marked as an address fault (indices 1 and 2 by default). Otherwise it keeps its previous value.
- R4: On the clock edge that accepts a request, `pc_load_o` and `flush_o` go high for exactly one cycle. `pc_target_o` becomes `vec_base_i + 16 * index`.
- R5: After entry, status bit 1 (supervisor) is 1 and bit 0 (recognition enable) is 0. All other status bits are unchanged.
- R6: A return strobe (`rfe_i`) with no request being accepted does three things on the next edge. It loads `esw_o` into the status word, sets `pc_target_o` to `epc_o`, and pulses `pc_load_o` and `flush_o`.
- R7: A request that arrives while status bit 0 is 0, even as a single-cycle pulse, stays pending. It is accepted on the first cycle after recognition is re-enabled, whether by a status write or by a return.
- R8: Accepting a request takes precedence over a return strobe and over a status write in the same cycle. Neither of those has any effect in that cycle.
- R9: After reset the status word is 0x02 (supervisor, recognition off), nothing is pending, and `pc_load_o`, `flush_o`, `cause_o`, `epc_o`, `esw_o` and `bad_addr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_REQ | Exception/interrupt request lines, index 0 highest priority |
| pc_i | input | XLEN | Address of the instruction being interrupted |
| fault_addr_i | input | XLEN | Memory address of a faulting access |
| vec_base_i | input | XLEN | Base of the handler vector table |
| rfe_i | input | 1 | Return-from-exception strobe |
| sw_we_i | input | 1 | Status word write strobe |
| sw_wdata_i | input | SW_W | Status word write data |
| status_o | output | SW_W | Current status word |
| pc_load_o | output | 1 | Program counter load pulse |
| pc_target_o | output | XLEN | Program counter value to load |
| flush_o | output | 1 | Flush of younger instructions |
| cause_o | output | IDXW | Index of the last accepted request |
| epc_o | output | XLEN | Shadowed instruction address |
| esw_o | output | SW_W | Shadowed status word |
| bad_addr_o | output | XLEN | Shadowed faulting memory address |

## Verification
The bench drives mixed request patterns and expects the lowest index to win. A reversed or partial priority encoder would report the wrong cause and the wrong vector address.

It pulses requests while recognition is off, then re-enables recognition both by a status write and by a return. A block that dropped unheld requests would never redirect. A block that ignored the enable bit would redirect early.

A second exception that follows a return must leave the faulting-address shadow untouched, which exposes a capture that is not qualified by cause. A request, a return and a status write all land in one cycle, and the bench checks that only the entry takes effect.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int SW_EE  = 0;  // recognition enable bit
  localparam int SW_SUP = 1;  // supervisor mode bit
endpackage

// File: rtl/exc_prio_arb.sv
module exc_prio_arb #(
  parameter int N    = 8,
  parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    vec_i,
  output logic            any_o,
  output logic [N-1:0]    onehot_o,
  output logic [IDXW-1:0] idx_o
);
  logic [N-1:0] seen;

  assign seen[0] = 1'b0;
  genvar g;
  generate
    for (g = 0; g < N - 1; g++) begin : g_chain
      assign seen[g+1] = seen[g] | vec_i[g];
    end
    for (g = 0; g < N; g++) begin : g_grant
      assign onehot_o[g] = vec_i[g] & ~seen[g];
    end
  endgenerate

  assign any_o = |vec_i;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot_o[i]) idx_o = idx_o | IDXW'(i);
    end
  end
endmodule

// File: rtl/exc_pending.sv
module exc_pending #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  always_ff @(posedge clk) begin
    if (rst) pend_o <= '0;
    else     pend_o <= (pend_o | set_i) & ~clr_i;
  end
endmodule

// File: rtl/exc_shadow.sv
module exc_shadow #(
  parameter int XLEN = 32,
  parameter int SW_W = 8,
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cap_i,
  input  logic            addr_cap_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [SW_W-1:0] sw_i,
  input  logic [XLEN-1:0] faddr_i,
  input  logic [IDXW-1:0] idx_i,
  output logic [XLEN-1:0] epc_o,
  output logic [SW_W-1:0] esw_o,
  output logic [XLEN-1:0] bad_o,
  output logic [IDXW-1:0] cause_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      epc_o   <= '0;
      esw_o   <= '0;
      cause_o <= '0;
    end else if (cap_i) begin
      epc_o   <= pc_i;
      esw_o   <= sw_i;
      cause_o <= idx_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             bad_o <= '0;
    else if (addr_cap_i) bad_o <= faddr_i;
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector #(
  parameter int XLEN        = 32,
  parameter int IDXW        = 3,
  parameter int STRIDE_LOG2 = 4
) (
  input  logic [XLEN-1:0] base_i,
  input  logic [IDXW-1:0] idx_i,
  output logic [XLEN-1:0] target_o
);
  assign target_o = base_i + (XLEN'(idx_i) << STRIDE_LOG2);
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl #(
  parameter int               NUM_REQ     = 8,
  parameter int               XLEN        = 32,
  parameter int               SW_W        = 8,
  parameter int               STRIDE_LOG2 = 4,
  parameter logic [NUM_REQ-1:0] ADDR_FAULT_MASK = 8'b0000_0110,
  parameter logic [SW_W-1:0]  SW_RESET    = 8'h02,
  localparam int              IDXW        = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    fault_addr_i,
  input  logic [XLEN-1:0]    vec_base_i,
  input  logic               rfe_i,
  input  logic               sw_we_i,
  input  logic [SW_W-1:0]    sw_wdata_i,
  output logic [SW_W-1:0]    status_o,
  output logic               pc_load_o,
  output logic [XLEN-1:0]    pc_target_o,
  output logic               flush_o,
  output logic [IDXW-1:0]    cause_o,
  output logic [XLEN-1:0]    epc_o,
  output logic [SW_W-1:0]    esw_o,
  output logic [XLEN-1:0]    bad_addr_o
);
  import exc_pkg::*;

  logic [NUM_REQ-1:0] pend_q;
  logic [NUM_REQ-1:0] pend_all_w;
  logic [NUM_REQ-1:0] grant_w;
  logic [NUM_REQ-1:0] clr_w;
  logic [IDXW-1:0]    win_idx_w;
  logic               any_w;
  logic               take_w;
  logic               rfe_go_w;
  logic               addr_cap_w;
  logic [XLEN-1:0]    vec_w;
  logic [SW_W-1:0]    entry_sw_w;

  // Requests seen this cycle compete together with the latched ones.
  assign pend_all_w = pend_q | req_i;

  exc_prio_arb #(.N(NUM_REQ), .IDXW(IDXW)) u_arb (
    .vec_i    (pend_all_w),
    .any_o    (any_w),
    .onehot_o (grant_w),
    .idx_o    (win_idx_w)
  );

  assign take_w     = any_w & status_o[SW_EE];
  assign clr_w      = take_w ? grant_w : '0;
  assign addr_cap_w = take_w & (|(grant_w & ADDR_FAULT_MASK));
  assign rfe_go_w   = rfe_i & ~take_w;

  exc_pending #(.N(NUM_REQ)) u_pend (
    .clk    (clk),
    .rst    (rst),
    .set_i  (req_i),
    .clr_i  (clr_w),
    .pend_o (pend_q)
  );

  exc_shadow #(.XLEN(XLEN), .SW_W(SW_W), .IDXW(IDXW)) u_shadow (
    .clk        (clk),
    .rst        (rst),
    .cap_i      (take_w),
    .addr_cap_i (addr_cap_w),
    .pc_i       (pc_i),
    .sw_i       (status_o),
    .faddr_i    (fault_addr_i),
    .idx_i      (win_idx_w),
    .epc_o      (epc_o),
    .esw_o      (esw_o),
    .bad_o      (bad_addr_o),
    .cause_o    (cause_o)
  );

  exc_vector #(.XLEN(XLEN), .IDXW(IDXW), .STRIDE_LOG2(STRIDE_LOG2)) u_vec (
    .base_i   (vec_base_i),
    .idx_i    (win_idx_w),
    .target_o (vec_w)
  );

  always_comb begin
    entry_sw_w         = status_o;
    entry_sw_w[SW_SUP] = 1'b1;
    entry_sw_w[SW_EE]  = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o    <= SW_RESET;
      pc_load_o   <= 1'b0;
      flush_o     <= 1'b0;
      pc_target_o <= '0;
    end else begin
      pc_load_o <= take_w | rfe_go_w;
      flush_o   <= take_w | rfe_go_w;
      if (take_w) begin
        status_o    <= entry_sw_w;
        pc_target_o <= vec_w;
      end else if (rfe_go_w) begin
        status_o    <= esw_o;
        pc_target_o <= epc_o;
      end else if (sw_we_i) begin
        status_o    <= sw_wdata_i;
      end
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int NUM_REQ     = 8,
  parameter int XLEN        = 32,
  parameter int SW_W        = 8,
  parameter int STRIDE_LOG2 = 4,
  parameter int IDXW        = 3
) (
  input logic               clk,
  input logic               rst,
  input logic [XLEN-1:0]    pc_i,
  input logic [XLEN-1:0]    vec_base_i,
  input logic               rfe_i,
  input logic [SW_W-1:0]    status_o,
  input logic               pc_load_o,
  input logic [XLEN-1:0]    pc_target_o,
  input logic               flush_o,
  input logic [IDXW-1:0]    cause_o,
  input logic [XLEN-1:0]    epc_o,
  input logic [SW_W-1:0]    esw_o,
  input logic [XLEN-1:0]    bad_addr_o,
  input logic               take_w,
  input logic [NUM_REQ-1:0] pend_all_w
);
  import exc_pkg::*;

  a_r1_lowest_wins: assert property (@(posedge clk) disable iff (rst)
    take_w |=> (($past(pend_all_w) & ((NUM_REQ'(1) << cause_o) - NUM_REQ'(1))) == '0)
               && (|($past(pend_all_w) & (NUM_REQ'(1) << cause_o))));

  a_r2_shadow_capture: assert property (@(posedge clk) disable iff (rst)
    take_w |=> (epc_o == $past(pc_i)) && (esw_o == $past(status_o)));

  a_r3_bad_addr_hold: assert property (@(posedge clk) disable iff (rst)
    !take_w |=> $stable(bad_addr_o));

  a_r4_vector_load: assert property (@(posedge clk) disable iff (rst)
    take_w |=> pc_load_o && flush_o &&
               (pc_target_o == $past(vec_base_i) + (XLEN'(cause_o) << STRIDE_LOG2)));

  a_r5_supervisor_entry: assert property (@(posedge clk) disable iff (rst)
    take_w |=> status_o[SW_SUP] && !status_o[SW_EE]);

  a_r6_return_restore: assert property (@(posedge clk) disable iff (rst)
    (rfe_i && !take_w) |=> pc_load_o && (status_o == $past(esw_o)) &&
                          (pc_target_o == $past(epc_o)));

  a_r7_no_entry_disabled: assert property (@(posedge clk) disable iff (rst)
    (!status_o[SW_EE] && !rfe_i) |=> !pc_load_o && !flush_o);
endmodule

bind exc_entry_ctrl exc_entry_chk #(
  .NUM_REQ(NUM_REQ), .XLEN(XLEN), .SW_W(SW_W),
  .STRIDE_LOG2(STRIDE_LOG2), .IDXW(IDXW)
) u_chk (
  .clk(clk), .rst(rst), .pc_i(pc_i), .vec_base_i(vec_base_i), .rfe_i(rfe_i),
  .status_o(status_o), .pc_load_o(pc_load_o), .pc_target_o(pc_target_o),
  .flush_o(flush_o), .cause_o(cause_o), .epc_o(epc_o), .esw_o(esw_o),
  .bad_addr_o(bad_addr_o), .take_w(take_w), .pend_all_w(pend_all_w)
);

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam int WATCHDOG_CYCLES = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  req_i = '0;
  logic [31:0] pc_i = '0, fault_addr_i = '0, vec_base_i = '0;
  logic        rfe_i = 1'b0, sw_we_i = 1'b0;
  logic [7:0]  sw_wdata_i = '0;
  logic [7:0]  status_o, esw_o;
  logic        pc_load_o, flush_o;
  logic [31:0] pc_target_o, epc_o, bad_addr_o;
  logic [2:0]  cause_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_ctrl u_exc_entry_ctrl (
    .clk(clk), .rst(rst), .req_i(req_i), .pc_i(pc_i), .fault_addr_i(fault_addr_i),
    .vec_base_i(vec_base_i), .rfe_i(rfe_i), .sw_we_i(sw_we_i), .sw_wdata_i(sw_wdata_i),
    .status_o(status_o), .pc_load_o(pc_load_o), .pc_target_o(pc_target_o),
    .flush_o(flush_o), .cause_o(cause_o), .epc_o(epc_o), .esw_o(esw_o),
    .bad_addr_o(bad_addr_o)
  );

  localparam logic [7:0]  T_REQ [NV] = '{8'h01, 8'h80, 8'hF0, 8'h06, 8'h0C, 8'hFF, 8'h44, 8'h88};
  localparam logic [2:0]  T_IDX [NV] = '{3'd0,  3'd7,  3'd4,  3'd1,  3'd2,  3'd0,  3'd2,  3'd3};
  localparam logic [31:0] T_PC  [NV] = '{32'h0000_0100, 32'h0000_2004, 32'h0001_0040, 32'h00AB_CDE0,
                                         32'h8000_0008, 32'h0000_0010, 32'h1234_5670, 32'hFFFF_FFFC};
  localparam logic [31:0] T_FA  [NV] = '{32'hDEAD_0000, 32'hDEAD_0001, 32'hDEAD_0002, 32'hCAFE_1230,
                                         32'hCAFE_4560, 32'hBEEF_0005, 32'hBEEF_0006, 32'hBEEF_0007};
  localparam logic [31:0] T_VB  [NV] = '{32'h0000_1000, 32'h0000_8000, 32'hFFFF_0000, 32'h0004_0000,
                                         32'h0000_0000, 32'h0010_0000, 32'h0000_F000, 32'h7FFF_FF00};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_i = '0; rfe_i = 1'b0; sw_we_i = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic write_sw(input logic [7:0] v);
    @(negedge clk);
    sw_we_i = 1'b1; sw_wdata_i = v;
    @(posedge clk);
    @(negedge clk);
    sw_we_i = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R9 reset state
    check("R9 status", 32'(status_o), 32'h02);
    check("R9 pc_load", 32'(pc_load_o), 0);
    check("R9 flush", 32'(flush_o), 0);
    check("R9 cause", 32'(cause_o), 0);
    check("R9 epc", epc_o, 0);
    check("R9 esw", 32'(esw_o), 0);
    check("R9 bad_addr", bad_addr_o, 0);

    // Table: R1 R2 R3 R4 R5
    for (int k = 0; k < NV; k++) begin
      do_reset();
      write_sw(8'hA1);
      @(negedge clk);
      req_i = T_REQ[k]; pc_i = T_PC[k]; fault_addr_i = T_FA[k]; vec_base_i = T_VB[k];
      @(posedge clk);
      @(negedge clk);
      req_i = '0;
      check("R1 cause", 32'(cause_o), 32'(T_IDX[k]));
      check("R4 pc_load", 32'(pc_load_o), 1);
      check("R4 flush", 32'(flush_o), 1);
      check("R4 target", pc_target_o, T_VB[k] + 32'(T_IDX[k]) * 16);
      check("R2 epc", epc_o, T_PC[k]);
      check("R2 esw", 32'(esw_o), 32'hA1);
      check("R5 status", 32'(status_o), 32'hA2);
      check("R3 bad_addr", bad_addr_o, (T_IDX[k] == 3'd1 || T_IDX[k] == 3'd2) ? T_FA[k] : 32'h0);
      @(posedge clk);
      @(negedge clk);
      check("R4 single pulse", 32'(pc_load_o), 0);
    end

    // R7: pulse while disabled stays pending, accepted after a status write
    do_reset();
    @(negedge clk);
    req_i = 8'h20; pc_i = 32'h0000_4440; vec_base_i = 32'h0000_2000;
    @(posedge clk);
    @(negedge clk);
    req_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 held off", 32'(pc_load_o), 0);
    write_sw(8'h01);
    check("R7 no entry on write edge", 32'(pc_load_o), 0);
    @(posedge clk);
    @(negedge clk);
    check("R7 pending taken", 32'(pc_load_o), 1);
    check("R7 cause", 32'(cause_o), 5);
    check("R7 target", pc_target_o, 32'h0000_2050);
    check("R7 epc", epc_o, 32'h0000_4440);

    // R6: return restores status and redirects to saved address
    @(negedge clk);
    rfe_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rfe_i = 1'b0;
    check("R6 status", 32'(status_o), 32'h01);
    check("R6 pc_load", 32'(pc_load_o), 1);
    check("R6 flush", 32'(flush_o), 1);
    check("R6 target", pc_target_o, 32'h0000_4440);

    // R7/R3: leftover request taken after return; bad address kept for non-address cause
    do_reset();
    write_sw(8'h01);
    @(negedge clk);
    req_i = 8'h0A; pc_i = 32'h0000_0A00; fault_addr_i = 32'hF1F1_0000; vec_base_i = 32'h0000_3000;
    @(posedge clk);
    @(negedge clk);
    req_i = '0;
    check("R1 cause of pair", 32'(cause_o), 1);
    check("R3 bad captured", bad_addr_o, 32'hF1F1_0000);
    fault_addr_i = 32'h5555_5555; pc_i = 32'h0000_0B00;
    rfe_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rfe_i = 1'b0;
    check("R6 return status", 32'(status_o), 32'h01);
    @(posedge clk);
    @(negedge clk);
    check("R7 leftover cause", 32'(cause_o), 3);
    check("R7 leftover load", 32'(pc_load_o), 1);
    check("R7 leftover target", pc_target_o, 32'h0000_3030);
    check("R3 bad kept", bad_addr_o, 32'hF1F1_0000);
    check("R2 epc second", epc_o, 32'h0000_0B00);

    // R8: entry beats return and status write in the same cycle
    do_reset();
    write_sw(8'h01);
    @(negedge clk);
    req_i = 8'h10; pc_i = 32'h0000_0C00; vec_base_i = 32'h0000_4000;
    rfe_i = 1'b1; sw_we_i = 1'b1; sw_wdata_i = 8'hF1;
    @(posedge clk);
    @(negedge clk);
    req_i = '0; rfe_i = 1'b0; sw_we_i = 1'b0;
    check("R8 cause", 32'(cause_o), 4);
    check("R8 status", 32'(status_o), 32'h02);
    check("R8 target", pc_target_o, 32'h0000_4040);
    check("R8 esw", 32'(esw_o), 32'h01);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule